// File: doc/BRIEF.md
# Probe-and-Refill Tag Store

This block is the tag directory of an external cache level. Every line index selects one stored tag and one valid bit. In each cycle the requester may start one access.

A probe compares the tag on the shared tag bus against the stored entry. It reports a hit one clock later. If the requester also asks for read-back, the block returns the stored tag and the line state in that same later cycle.

A write (refill) stores a tag and a valid flag at the addressed line. A separate capture strobe copies the tag bus into an internal holding latch. A later refill then commits the held tag, so the bus is free to carry other traffic between lookup and refill.

The request side has no back-pressure: an access is accepted in every cycle it is presented. The read-back side is a qualified output. `rd_vld` marks the one cycle in which `rd_tag` and `rd_line_vld` carry data, and both are zero at all other times.

Top module: `tag_probe_ram`

## Requirements
- R1: With `ce`=1 and `we`=0 (probe), `match` is 1 in the next cycle exactly when the addressed line is valid and its stored tag equals `tag_in`.
- R2: With `ce`=1 and `we`=1 (write), the addressed line takes the write tag and takes `valid_in` as its valid bit. No other line changes.
- R3: `de`=1 copies `tag_in` into the holding latch. The latch keeps that value through any number of cycles with `de`=0.
- R4: A write with `de`=0 stores the latch contents, whatever is on `tag_in`. A write with `de`=1 stores `tag_in`, and also latches it.
- R5: A line whose valid bit is 0 never produces `match`=1, even when the tags are equal.
- R6: A probe with `oe`=1 gives, in the next cycle, `rd_vld`=1, `rd_tag` set to the stored tag and `rd_line_vld` set to the stored valid bit. In every other cycle, all three outputs are 0.
- R7: Results appear one clock after the access. A probe in the cycle right after a write to the same line sees the newly written contents.
- R8: A synchronous reset (`rst`=1) clears every valid bit, the latch, `match` and the read-back outputs.
- R9: When `ce`=0, or the access is a write, `match` and `rd_vld` are 0 in the next cycle and the stored contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Access strobe |
| we | input | 1 | 1 = write, 0 = probe |
| de | input | 1 | Capture `tag_in` into the holding latch |
| oe | input | 1 | Request read-back on a probe |
| index | input | IDX_W | Line index |
| tag_in | input | TAG_W | Shared tag bus |
| valid_in | input | 1 | Valid bit to store on a write |
| match | output | 1 | Probe hit, one cycle after the probe |
| rd_vld | output | 1 | Read-back data valid |
| rd_tag | output | TAG_W | Stored tag read back |
| rd_line_vld | output | 1 | Stored valid bit read back |

## Verification
The bench builds the block with `IDX_W`=4 and `TAG_W`=8. With these values, 16 lines and 8-bit tags are small enough to set up by hand. Tags that differ by one bit check the comparator, and neighbouring lines check that a write reaches only its own entry. The narrow index also keeps write-then-probe sequences on the same line short. This makes it practical to cover a latch reused across several refills and a reset in the middle of the run that drops valid state while the tag bits stay in the array.

// File: rtl/tag_probe_pkg.sv
package tag_probe_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_PROBE = 2'd1,
    OP_WRITE = 2'd2
  } tag_op_e;

  function automatic tag_op_e decode_op(input logic ce, input logic we);
    if (!ce) return OP_IDLE;
    return we ? OP_WRITE : OP_PROBE;
  endfunction
endpackage

// File: rtl/tag_hold_latch.sv
module tag_hold_latch #(
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [TAG_W-1:0] bus,
  output logic [TAG_W-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst)      held <= '0;
    else if (cap) held <= bus;
  end
endmodule

// File: rtl/tag_line_array.sv
module tag_line_array #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] wtag,
  input  logic             wvld,
  output logic [TAG_W-1:0] rtag,
  output logic             rvld
);
  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] tags [DEPTH];
  logic [DEPTH-1:0] vbits;

  always_ff @(posedge clk) begin
    if (wr) tags[idx] <= wtag;
  end

  always_ff @(posedge clk) begin
    if (rst)     vbits <= '0;
    else if (wr) vbits[idx] <= wvld;
  end

  assign rtag = tags[idx];
  assign rvld = vbits[idx];
endmodule

// File: rtl/tag_result_stage.sv
module tag_result_stage #(
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             probe,
  input  logic             want_rd,
  input  logic [TAG_W-1:0] cmp_tag,
  input  logic [TAG_W-1:0] st_tag,
  input  logic             st_vld,
  output logic             hit,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_line_vld
);
  logic do_rd;
  assign do_rd = probe && want_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit         <= 1'b0;
      rd_vld      <= 1'b0;
      rd_tag      <= '0;
      rd_line_vld <= 1'b0;
    end else begin
      hit         <= probe && st_vld && (st_tag == cmp_tag);
      rd_vld      <= do_rd;
      rd_tag      <= do_rd ? st_tag : '0;
      rd_line_vld <= do_rd && st_vld;
    end
  end
endmodule

// File: rtl/tag_probe_ram.sv
module tag_probe_ram #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             we,
  input  logic             de,
  input  logic             oe,
  input  logic [IDX_W-1:0] index,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             valid_in,
  output logic             match,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_line_vld
);
  import tag_probe_pkg::*;

  tag_op_e          op;
  logic [TAG_W-1:0] held_tag;
  logic [TAG_W-1:0] wr_tag;
  logic [TAG_W-1:0] st_tag;
  logic             st_vld;

  assign op     = decode_op(ce, we);
  assign wr_tag = de ? tag_in : held_tag;

  tag_hold_latch #(.TAG_W(TAG_W)) u_latch (
    .clk (clk),
    .rst (rst),
    .cap (de),
    .bus (tag_in),
    .held(held_tag)
  );

  tag_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk (clk),
    .rst (rst),
    .wr  (op == OP_WRITE),
    .idx (index),
    .wtag(wr_tag),
    .wvld(valid_in),
    .rtag(st_tag),
    .rvld(st_vld)
  );

  tag_result_stage #(.TAG_W(TAG_W)) u_result (
    .clk        (clk),
    .rst        (rst),
    .probe      (op == OP_PROBE),
    .want_rd    (oe),
    .cmp_tag    (tag_in),
    .st_tag     (st_tag),
    .st_vld     (st_vld),
    .hit        (match),
    .rd_vld     (rd_vld),
    .rd_tag     (rd_tag),
    .rd_line_vld(rd_line_vld)
  );
endmodule

// File: rtl/tag_probe_ram_chk.sv
module tag_probe_ram_chk #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic             we,
  input logic             de,
  input logic             oe,
  input logic [IDX_W-1:0] index,
  input logic [TAG_W-1:0] tag_in,
  input logic             valid_in,
  input logic             match,
  input logic             rd_vld,
  input logic [TAG_W-1:0] rd_tag,
  input logic             rd_line_vld,
  input logic [TAG_W-1:0] held_tag
);
  assert_match_needs_probe_R9: assert property (@(posedge clk) disable iff (rst)
    match |-> $past(ce && !we));

  assert_rdvld_needs_oe_probe_R6: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(ce && !we && oe));

  assert_idle_readback_zero_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_vld |-> (rd_tag == '0 && !rd_line_vld));

  assert_latch_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !de |=> $stable(held_tag));

  assert_latch_captures_R3: assert property (@(posedge clk) disable iff (rst)
    de |=> held_tag == $past(tag_in));

  assert_invalidated_no_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (ce && !we && $past(ce && we && !valid_in) && index == $past(index)) |=> !match);

  assert_hit_implies_line_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (match && $past(oe)) |-> rd_line_vld);
endmodule

bind tag_probe_ram tag_probe_ram_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .ce(ce), .we(we), .de(de), .oe(oe),
  .index(index), .tag_in(tag_in), .valid_in(valid_in),
  .match(match), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_line_vld(rd_line_vld),
  .held_tag(held_tag)
);

// File: tb/test_tag_probe_ram.sv
module test_tag_probe_ram;
  localparam int IDX_W = 4;
  localparam int TAG_W = 8;
  localparam int NV    = 14;

  typedef struct packed {
    logic       ce, we, de, oe, vin;
    logic [3:0] idx;
    logic [7:0] tag;
    logic       em, erv;
    logic [7:0] etag;
    logic       elv;
  } vec_t;

  // Fields: ce we de oe vin idx tag | match rd_vld rd_tag rd_line_vld
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0, 4'd0, 8'hA5, 1'b0,1'b0,8'h00,1'b0}, // R3 capture A5
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 4'd3, 8'h00, 1'b0,1'b0,8'h00,1'b0}, // R4 refill from latch
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 4'd3, 8'hA5, 1'b1,1'b1,8'hA5,1'b1}, // R1 R6 hit + read
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 4'd3, 8'hA4, 1'b0,1'b0,8'h00,1'b0}, // R1 one-bit miss
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 4'd4, 8'hA5, 1'b0,1'b0,8'h00,1'b0}, // R5 line 4 invalid
    '{1'b1,1'b1,1'b1,1'b0,1'b1, 4'd4, 8'h3C, 1'b0,1'b0,8'h00,1'b0}, // R4 bypass write
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 4'd4, 8'h3C, 1'b1,1'b1,8'h3C,1'b1}, // R7 back-to-back
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 4'd3, 8'hA5, 1'b1,1'b0,8'h00,1'b0}, // R2 line 3 untouched
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 4'd3, 8'hFF, 1'b0,1'b0,8'h00,1'b0}, // R9 write, oe ignored
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 4'd3, 8'h3C, 1'b0,1'b1,8'h3C,1'b0}, // R5 equal tag, invalid
    '{1'b0,1'b0,1'b0,1'b1,1'b0, 4'd3, 8'h3C, 1'b0,1'b0,8'h00,1'b0}, // R9 idle cycle
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 4'd9, 8'h11, 1'b0,1'b0,8'h00,1'b0}, // R3 latch reused
    '{1'b1,1'b1,1'b0,1'b0,1'b1, 4'd10,8'h22, 1'b0,1'b0,8'h00,1'b0}, // R3 latch reused again
    '{1'b1,1'b0,1'b0,1'b1,1'b0, 4'd10,8'h3C, 1'b1,1'b1,8'h3C,1'b1}  // R3 R4 held tag stored
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             ce, we, de, oe, valid_in;
  logic [IDX_W-1:0] index;
  logic [TAG_W-1:0] tag_in;
  logic             match, rd_vld, rd_line_vld;
  logic [TAG_W-1:0] rd_tag;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tag_probe_ram #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tag_probe_ram (
    .clk(clk), .rst(rst), .ce(ce), .we(we), .de(de), .oe(oe),
    .index(index), .tag_in(tag_in), .valid_in(valid_in),
    .match(match), .rd_vld(rd_vld), .rd_tag(rd_tag), .rd_line_vld(rd_line_vld)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic w, input logic d, input logic o,
                       input logic v, input logic [3:0] i, input logic [7:0] t);
    ce = c; we = w; de = d; oe = o; valid_in = v; index = i; tag_in = t;
  endtask

  task automatic chk_out(input string req, input logic em, input logic erv,
                         input logic [7:0] etag, input logic elv);
    chk(req, "match",       {31'd0, match},       {31'd0, em});
    chk(req, "rd_vld",      {31'd0, rd_vld},      {31'd0, erv});
    chk(req, "rd_tag",      {24'd0, rd_tag},      {24'd0, etag});
    chk(req, "rd_line_vld", {31'd0, rd_line_vld}, {31'd0, elv});
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(0,0,0,0,0,4'd0,8'h00);
    repeat (3) @(negedge clk);
    chk_out("R8", 1'b0, 1'b0, 8'h00, 1'b0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      drive(TBL[k].ce, TBL[k].we, TBL[k].de, TBL[k].oe, TBL[k].vin, TBL[k].idx, TBL[k].tag);
      @(negedge clk);
      chk_out($sformatf("R1-vec%0d", k), TBL[k].em, TBL[k].erv, TBL[k].etag, TBL[k].elv);
    end

    // R8: reset mid-run drops valid bits; tag contents remain readable.
    rst = 1'b1;
    drive(0,0,0,0,0,4'd0,8'h00);
    @(negedge clk);
    rst = 1'b0;
    drive(1,0,0,1,0,4'd4,8'h3C);
    @(negedge clk);
    chk_out("R8", 1'b0, 1'b1, 8'h3C, 1'b0);

    // R8: latch cleared by reset, so a refill without capture stores 00.
    drive(1,1,0,0,1,4'd5,8'h77);
    @(negedge clk);
    drive(1,0,0,1,0,4'd5,8'h00);
    @(negedge clk);
    chk_out("R8", 1'b1, 1'b1, 8'h00, 1'b1);

    // R7: write then immediate probe of the same line, then overwrite and probe.
    drive(1,1,1,0,1,4'd15,8'h81);
    @(negedge clk);
    drive(1,0,0,0,0,4'd15,8'h81);
    @(negedge clk);
    chk_out("R7", 1'b1, 1'b0, 8'h00, 1'b0);
    drive(1,1,1,0,1,4'd15,8'h82);
    @(negedge clk);
    drive(1,0,0,0,0,4'd15,8'h81);
    @(negedge clk);
    chk_out("R7", 1'b0, 1'b0, 8'h00, 1'b0);

    drive(0,0,0,0,0,4'd0,8'h00);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule